// File: doc/BRIEF.md
# Inset Window and Border Generator

This block produces the raster timing for a picture-in-picture inset drawn on top of the main display. It runs on the display luma clock. It counts pixels and lines from the main horizontal and vertical sync pulses, which are both active-low. From those counts it decides on every clock three things: whether the current pixel belongs to the inset window, whether it belongs to the border around the window, and which stored inset sample to fetch.

The origin of the window comes from two 8-bit position fields. The height depends on the video standard: 72 lines for NTSC and 84 lines for PAL. The width is 180 luma samples, with 44 samples for each colour-difference component. The border is reported on a dedicated pulse output in every case. When colour-border mode is on, the border is also reported as a substitution flag together with three 4-bit colour components.

All outputs follow the raster and have no back-pressure. `rd_en` is a one-clock strobe that the memory side must accept in the same cycle, because the raster cannot stall. Any read latency of the memory is compensated outside this block.

Top module: `inset_window_gen`

## Requirements
- R1: The clock edge that first samples `hsync_n` low makes the following cycle pixel 0. The same edge makes it line 0 when `vsync_n` is also sampled low; otherwise the line count advances by one. Every output is registered and presents the decision for pixel x one clock after the cycle in which the pixel count equals x.
- R2: The window covers pixels x0 to x0+LUMA_W-1 on lines y0 to y0+L-1, where x0 = `hpos` × H_SCALE and y0 = `vpos`. `sel_inset` is 1 exactly inside the window (1 = inset, 0 = main picture).
- R3: With `fmt_ntsc` = 1 the window height L is LINES_NTSC (default 72). With `fmt_ntsc` = 0 it is LINES_PAL (default 84).
- R4: While `show_en` is 0, `sel_inset`, `border_pulse`, `border_ovr` and `rd_en` stay 0.
- R5: `border_pulse` is 1 on the ring just outside the window: one line above it, one line below it, and two pixels to its left and right, corners included. Any part of the ring that would lie before pixel 0 or line 0 is not drawn.
- R6: `border_pulse` does not depend on `color_border_en`. `border_ovr` equals `border_pulse` AND `color_border_en`. `ovr_y`, `ovr_ry` and `ovr_by` carry the programmed 4-bit colour while `border_ovr` is 1 and are 0 otherwise.
- R7: Inside the window, `rd_en` is 1, `luma_idx` counts 0 to LUMA_W-1 from the left edge, and `line_idx` equals the line minus y0. Outside the window all three are 0.
- R8: Inside the window, `chroma_idx` equals `luma_idx` divided by CHROMA_DIV (default 4), rounded down and capped at CHROMA_W-1 (default 43). Outside the window it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display luma clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_n | input | 1 | Main horizontal sync, active-low |
| vsync_n | input | 1 | Main vertical sync, active-low |
| show_en | input | 1 | Inset display enable |
| fmt_ntsc | input | 1 | Standard select, 1 = NTSC height, 0 = PAL height |
| color_border_en | input | 1 | Enable colour substitution on the border |
| vpos | input | 8 | Window top line |
| hpos | input | 8 | Window left position, in units of H_SCALE pixels |
| brd_y | input | 4 | Border colour, luma |
| brd_ry | input | 4 | Border colour, R-Y |
| brd_by | input | 4 | Border colour, B-Y |
| sel_inset | output | 1 | 1 selects the inset, 0 the main picture |
| border_pulse | output | 1 | High on border positions |
| border_ovr | output | 1 | Border colour substitution active |
| ovr_y | output | 4 | Substituted luma |
| ovr_ry | output | 4 | Substituted R-Y |
| ovr_by | output | 4 | Substituted B-Y |
| rd_en | output | 1 | Read strobe for the stored inset sample |
| luma_idx | output | LUMA_AW (8) | Luma sample index within the line |
| chroma_idx | output | CHROMA_AW (6) | Chroma sample index within the line |
| line_idx | output | LINE_AW (7) | Inset line index |

## Verification
The bench builds the block with a reduced window: LUMA_W = 12, LINES_NTSC = 3, LINES_PAL = 5, CHROMA_W = 2, CHROMA_DIV = 4 and H_SCALE = 2, with 8-bit and 6-bit counters. With these values a whole frame can be compared pixel by pixel against a model on short lines of 32 clocks. The narrow chroma width makes the cap on the chroma index appear within a single line. A zero origin places the clipped left and top border inside the scanned area. Both standards can be run back to back, and so can the states of the display and colour-border enables.

// File: rtl/iwg_pkg.sv
package iwg_pkg;

  typedef struct packed {
    logic [3:0] y;
    logic [3:0] ry;
    logic [3:0] by;
  } iwg_colour_t;

  localparam iwg_colour_t IWG_NO_COLOUR = '{y: 4'd0, ry: 4'd0, by: 4'd0};

  function automatic int iwg_addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/iwg_raster_count.sv
module iwg_raster_count #(
  parameter int HCNT_W = 10,
  parameter int VCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_n,
  input  logic              vsync_n,
  output logic [HCNT_W-1:0] hcnt,
  output logic [VCNT_W-1:0] vcnt
);
  localparam logic [HCNT_W-1:0] HMAX = '1;
  localparam logic [VCNT_W-1:0] VMAX = '1;

  logic hs_q, vs_q;
  logic h_fall, v_fall;

  assign h_fall = hs_q & ~hsync_n;
  assign v_fall = vs_q & ~vsync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hs_q <= hsync_n;
      vs_q <= vsync_n;
      if (h_fall)            hcnt <= '0;
      else if (hcnt != HMAX) hcnt <= hcnt + 1'b1;
      if (v_fall)                      vcnt <= '0;
      else if (h_fall && vcnt != VMAX) vcnt <= vcnt + 1'b1;
    end
  end
endmodule

// File: rtl/iwg_win_decode.sv
module iwg_win_decode #(
  parameter int HCNT_W     = 10,
  parameter int VCNT_W     = 9,
  parameter int LUMA_W     = 180,
  parameter int LINES_NTSC = 72,
  parameter int LINES_PAL  = 84,
  parameter int H_SCALE    = 2,
  parameter int BORDER_W   = 2,
  parameter int BORDER_H   = 1,
  parameter int LINE_AW    = 7
) (
  input  logic [HCNT_W-1:0]  hcnt,
  input  logic [VCNT_W-1:0]  vcnt,
  input  logic [7:0]         hpos,
  input  logic [7:0]         vpos,
  input  logic               fmt_ntsc,
  output logic               in_win,
  output logic               in_border,
  output logic               win_first,
  output logic [LINE_AW-1:0] line_off
);
  localparam int XW = HCNT_W + 12;
  localparam int YW = VCNT_W + 12;

  logic [XW-1:0] x, x0, xe;
  logic [YW-1:0] y, y0, ye, nlines, dy;
  logic in_x, in_y, near_x, near_y;

  always_comb begin
    x      = XW'(hcnt);
    y      = YW'(vcnt);
    x0     = XW'(hpos) * XW'(H_SCALE);
    y0     = YW'(vpos);
    nlines = fmt_ntsc ? YW'(LINES_NTSC) : YW'(LINES_PAL);
    xe     = x0 + XW'(LUMA_W);
    ye     = y0 + nlines;
    in_x   = (x >= x0) && (x < xe);
    in_y   = (y >= y0) && (y < ye);
    near_x = (x + XW'(BORDER_W) >= x0) && (x < xe + XW'(BORDER_W));
    near_y = (y + YW'(BORDER_H) >= y0) && (y < ye + YW'(BORDER_H));
    dy     = y - y0;
  end

  assign in_win    = in_x && in_y;
  assign in_border = near_x && near_y && !in_win;
  assign win_first = (x == x0);
  assign line_off  = dy[LINE_AW-1:0];
endmodule

// File: rtl/iwg_read_addr.sv
module iwg_read_addr #(
  parameter int CHROMA_W   = 44,
  parameter int CHROMA_DIV = 4,
  parameter int LUMA_AW    = 8,
  parameter int CHROMA_AW  = 6,
  parameter int LINE_AW    = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic [LINE_AW-1:0]   line_off,
  output logic [LUMA_AW-1:0]   luma_idx,
  output logic [CHROMA_AW-1:0] chroma_idx,
  output logic [LINE_AW-1:0]   line_idx
);
  localparam logic [CHROMA_AW-1:0] CLAST = CHROMA_AW'(CHROMA_W - 1);

  logic [CHROMA_AW-1:0] c_inc;
  assign c_inc = (chroma_idx == CLAST) ? chroma_idx : chroma_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_idx <= '0;
      line_idx <= '0;
    end else if (en) begin
      luma_idx <= first ? '0 : luma_idx + 1'b1;
      line_idx <= line_off;
    end else begin
      luma_idx <= '0;
      line_idx <= '0;
    end
  end

  generate
    if (CHROMA_DIV == 1) begin : g_full_rate
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chroma_idx <= '0;
        else if (en)  chroma_idx <= first ? '0 : c_inc;
        else          chroma_idx <= '0;
      end
    end else begin : g_divided
      localparam int PW = $clog2(CHROMA_DIV);
      localparam logic [PW-1:0] PLAST = PW'(CHROMA_DIV - 1);
      logic [PW-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase      <= '0;
          chroma_idx <= '0;
        end else if (en && first) begin
          phase      <= '0;
          chroma_idx <= '0;
        end else if (en) begin
          if (phase == PLAST) begin
            phase      <= '0;
            chroma_idx <= c_inc;
          end else begin
            phase      <= phase + 1'b1;
          end
        end else begin
          phase      <= '0;
          chroma_idx <= '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/inset_window_gen.sv
module inset_window_gen
  import iwg_pkg::*;
#(
  parameter int HCNT_W     = 10,
  parameter int VCNT_W     = 9,
  parameter int LUMA_W     = 180,
  parameter int CHROMA_W   = 44,
  parameter int CHROMA_DIV = 4,
  parameter int LINES_NTSC = 72,
  parameter int LINES_PAL  = 84,
  parameter int H_SCALE    = 2,
  parameter int LUMA_AW    = iwg_addr_bits(LUMA_W),
  parameter int CHROMA_AW  = iwg_addr_bits(CHROMA_W),
  parameter int LINE_AW    = iwg_addr_bits((LINES_NTSC > LINES_PAL) ? LINES_NTSC : LINES_PAL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hsync_n,
  input  logic                 vsync_n,
  input  logic                 show_en,
  input  logic                 fmt_ntsc,
  input  logic                 color_border_en,
  input  logic [7:0]           vpos,
  input  logic [7:0]           hpos,
  input  logic [3:0]           brd_y,
  input  logic [3:0]           brd_ry,
  input  logic [3:0]           brd_by,
  output logic                 sel_inset,
  output logic                 border_pulse,
  output logic                 border_ovr,
  output logic [3:0]           ovr_y,
  output logic [3:0]           ovr_ry,
  output logic [3:0]           ovr_by,
  output logic                 rd_en,
  output logic [LUMA_AW-1:0]   luma_idx,
  output logic [CHROMA_AW-1:0] chroma_idx,
  output logic [LINE_AW-1:0]   line_idx
);
  localparam int BORDER_W = 2;
  localparam int BORDER_H = 1;

  logic [HCNT_W-1:0]  hcnt;
  logic [VCNT_W-1:0]  vcnt;
  logic               in_win, in_border, win_first;
  logic [LINE_AW-1:0] line_off;
  logic               rd_next, brd_next, ovr_next;
  iwg_colour_t        colour_q, colour_next;

  iwg_raster_count #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .hcnt(hcnt), .vcnt(vcnt)
  );

  iwg_win_decode #(
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .LUMA_W(LUMA_W),
    .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL), .H_SCALE(H_SCALE),
    .BORDER_W(BORDER_W), .BORDER_H(BORDER_H), .LINE_AW(LINE_AW)
  ) u_decode (
    .hcnt(hcnt), .vcnt(vcnt), .hpos(hpos), .vpos(vpos), .fmt_ntsc(fmt_ntsc),
    .in_win(in_win), .in_border(in_border), .win_first(win_first),
    .line_off(line_off)
  );

  assign rd_next  = show_en && in_win;
  assign brd_next = show_en && in_border;
  assign ovr_next = brd_next && color_border_en;

  always_comb begin
    colour_next = IWG_NO_COLOUR;
    if (ovr_next) colour_next = '{y: brd_y, ry: brd_ry, by: brd_by};
  end

  iwg_read_addr #(
    .CHROMA_W(CHROMA_W), .CHROMA_DIV(CHROMA_DIV), .LUMA_AW(LUMA_AW),
    .CHROMA_AW(CHROMA_AW), .LINE_AW(LINE_AW)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .en(rd_next), .first(win_first),
    .line_off(line_off), .luma_idx(luma_idx), .chroma_idx(chroma_idx),
    .line_idx(line_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_inset    <= 1'b0;
      rd_en        <= 1'b0;
      border_pulse <= 1'b0;
      border_ovr   <= 1'b0;
      colour_q     <= IWG_NO_COLOUR;
    end else begin
      sel_inset    <= rd_next;
      rd_en        <= rd_next;
      border_pulse <= brd_next;
      border_ovr   <= ovr_next;
      colour_q     <= colour_next;
    end
  end

  assign ovr_y  = colour_q.y;
  assign ovr_ry = colour_q.ry;
  assign ovr_by = colour_q.by;
endmodule

// File: rtl/iwg_checker.sv
module iwg_checker #(
  parameter int CHROMA_W  = 44,
  parameter int LUMA_AW   = 8,
  parameter int CHROMA_AW = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 show_en,
  input logic                 sel_inset,
  input logic                 border_pulse,
  input logic                 border_ovr,
  input logic [3:0]           ovr_y,
  input logic [3:0]           ovr_ry,
  input logic [3:0]           ovr_by,
  input logic                 rd_en,
  input logic [LUMA_AW-1:0]   luma_idx,
  input logic [CHROMA_AW-1:0] chroma_idx
);
  AST_HIDDEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !show_en |=> !(sel_inset || border_pulse || border_ovr || rd_en)); // R4

  AST_BORDER_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_inset && border_pulse)); // R5

  AST_OVR_ON_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    border_ovr |-> border_pulse); // R6

  AST_OVR_COLOUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !border_ovr |-> (ovr_y == 4'd0 && ovr_ry == 4'd0 && ovr_by == 4'd0)); // R6

  AST_LUMA_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> (luma_idx == '0 && chroma_idx == '0)); // R7

  AST_LUMA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> luma_idx == $past(luma_idx) + LUMA_AW'(1)); // R7

  AST_CHROMA_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    chroma_idx <= CHROMA_AW'(CHROMA_W - 1)); // R8

  AST_CHROMA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |->
      (chroma_idx == $past(chroma_idx) || chroma_idx == $past(chroma_idx) + CHROMA_AW'(1))); // R8
endmodule

bind inset_window_gen iwg_checker #(
  .CHROMA_W(CHROMA_W), .LUMA_AW(LUMA_AW), .CHROMA_AW(CHROMA_AW)
) u_iwg_checker (
  .clk(clk), .rst_n(rst_n), .show_en(show_en), .sel_inset(sel_inset),
  .border_pulse(border_pulse), .border_ovr(border_ovr), .ovr_y(ovr_y),
  .ovr_ry(ovr_ry), .ovr_by(ovr_by), .rd_en(rd_en), .luma_idx(luma_idx),
  .chroma_idx(chroma_idx)
);

// File: tb/tb_inset_window_gen.sv
module tb_inset_window_gen;
  localparam int LUMA_W = 12, CHROMA_W = 2, CHROMA_DIV = 4;
  localparam int LN_NTSC = 3, LN_PAL = 5, H_SCALE = 2;
  localparam int LUMA_AW = 4, CHROMA_AW = 1, LINE_AW = 3;
  localparam int LINE = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync_n = 1'b1, vsync_n = 1'b1;
  logic show_en = 1'b0, fmt_ntsc = 1'b1, color_border_en = 1'b0;
  logic [7:0] vpos = 8'd2, hpos = 8'd3;
  logic [3:0] brd_y = 4'd9, brd_ry = 4'd5, brd_by = 4'd12;
  logic sel_inset, border_pulse, border_ovr, rd_en;
  logic [3:0] ovr_y, ovr_ry, ovr_by;
  logic [LUMA_AW-1:0] luma_idx;
  logic [CHROMA_AW-1:0] chroma_idx;
  logic [LINE_AW-1:0] line_idx;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inset_window_gen #(
    .HCNT_W(8), .VCNT_W(6), .LUMA_W(LUMA_W), .CHROMA_W(CHROMA_W),
    .CHROMA_DIV(CHROMA_DIV), .LINES_NTSC(LN_NTSC), .LINES_PAL(LN_PAL),
    .H_SCALE(H_SCALE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .show_en(show_en), .fmt_ntsc(fmt_ntsc), .color_border_en(color_border_en),
    .vpos(vpos), .hpos(hpos), .brd_y(brd_y), .brd_ry(brd_ry), .brd_by(brd_by),
    .sel_inset(sel_inset), .border_pulse(border_pulse), .border_ovr(border_ovr),
    .ovr_y(ovr_y), .ovr_ry(ovr_ry), .ovr_by(ovr_by), .rd_en(rd_en),
    .luma_idx(luma_idx), .chroma_idx(chroma_idx), .line_idx(line_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors <= 25) $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_pixel(input int x, input int y);
    int x0, y0, nl, dx, cx;
    bit win, brd, ovr;
    x0  = int'(hpos) * H_SCALE;
    y0  = int'(vpos);
    nl  = fmt_ntsc ? LN_NTSC : LN_PAL;
    win = show_en && x >= x0 && x < x0 + LUMA_W && y >= y0 && y < y0 + nl;
    brd = show_en && !win && x + 2 >= x0 && x < x0 + LUMA_W + 2 &&
          y + 1 >= y0 && y < y0 + nl + 1;
    ovr = brd && color_border_en;
    dx  = win ? x - x0 : 0;
    cx  = dx / CHROMA_DIV;
    if (cx > CHROMA_W - 1) cx = CHROMA_W - 1;
    chk($sformatf("R1 R2 R3 sel x=%0d y=%0d", x, y), int'(sel_inset), int'(win));
    chk($sformatf("R5 border x=%0d y=%0d", x, y), int'(border_pulse), int'(brd));
    chk($sformatf("R6 ovr x=%0d y=%0d", x, y), int'(border_ovr), int'(ovr));
    chk($sformatf("R6 colour x=%0d y=%0d", x, y), int'({ovr_y, ovr_ry, ovr_by}),
        ovr ? int'({brd_y, brd_ry, brd_by}) : 0);
    chk($sformatf("R7 rd_en x=%0d y=%0d", x, y), int'(rd_en), int'(win));
    chk($sformatf("R7 luma x=%0d y=%0d", x, y), int'(luma_idx), dx);
    chk($sformatf("R7 line x=%0d y=%0d", x, y), int'(line_idx), win ? y - y0 : 0);
    chk($sformatf("R8 chroma x=%0d y=%0d", x, y), int'(chroma_idx), win ? cx : 0);
  endtask

  // called at a falling clock edge; one-clock sync pulse, then LINE samples
  task automatic run_line(input int y, input bit frame_start);
    hsync_n = 1'b0;
    vsync_n = frame_start ? 1'b0 : 1'b1;
    @(negedge clk);
    hsync_n = 1'b1;
    vsync_n = 1'b1;
    for (int k = 0; k < LINE; k++) begin
      @(negedge clk);
      check_pixel(k, y);
    end
  endtask

  task automatic run_frame();
    int nl = fmt_ntsc ? LN_NTSC : LN_PAL;
    for (int y = 0; y < int'(vpos) + nl + 3; y++) run_line(y, y == 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset sel", int'(sel_inset), 0);
    chk("R1 reset border", int'(border_pulse), 0);
    chk("R1 reset rd_en", int'(rd_en), 0);
    chk("R6 reset colour", int'({ovr_y, ovr_ry, ovr_by}), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_ntsc_plain();   // R2 R3 R5 R7 R8, colour off
    show_en = 1'b1; fmt_ntsc = 1'b1; color_border_en = 1'b0;
    hpos = 8'd3; vpos = 8'd2;
    run_frame();
  endtask

  task automatic t_pal_colour();   // R3 R6
    fmt_ntsc = 1'b0; color_border_en = 1'b1;
    hpos = 8'd5; vpos = 8'd1;
    run_frame();
  endtask

  task automatic t_origin_clip();  // R5 clipping at pixel 0 / line 0
    fmt_ntsc = 1'b1; color_border_en = 1'b1;
    hpos = 8'd0; vpos = 8'd0;
    run_frame();
  endtask

  task automatic t_hidden();       // R4
    show_en = 1'b0; color_border_en = 1'b1;
    hpos = 8'd2; vpos = 8'd1;
    run_frame();
  endtask

  task automatic t_colour_change(); // R6 new colour, NTSC again
    show_en = 1'b1; brd_y = 4'd15; brd_ry = 4'd0; brd_by = 4'd3;
    hpos = 8'd4; vpos = 8'd3;
    run_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ntsc_plain();
    t_pal_colour();
    t_origin_clip();
    t_hidden();
    t_colour_change();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule